// File: doc/BRIEF.md
# Interlace-Capable Video Timing Generator

This block produces the raster timing for a parallel RGB panel or a digital video transmitter. It has a horizontal pixel counter, a vertical line counter, a data-enable strobe, horizontal, vertical and composite sync, and a field identifier. Every count is taken from the top-left pixel of the active picture. Active pixels are at horizontal count 0 up to the active width, and active lines are at vertical count 0 up to the active height. Sync and blanking follow after the active area.

Software gives two field geometry sets, A and B. Each set holds a packed total (vertical total in bits 31:16, horizontal total in bits 15:0), a packed vertical margin word, and the horizontal pixel at which VSYNC changes state. All geometry inputs, the active size and the horizontal margins are copied into live registers only at a field boundary, or while the output is disabled. A field can therefore never change shape part-way through.

In interlaced operation the fields alternate between set A (first field, field output 0) and set B (second field, field output 1). A typical first field is one line longer, with one more line before VSYNC and a VSYNC start half a line earlier. The number of lines after VSYNC stays the same in both fields. In progressive operation only set A is used.

Top module: `ilace_vtg`

## Requirements
- R1: While `rst_n` is low, and while the output is disabled, `hcount`, `vcount`, `field` and `de` are 0, and each sync output sits at its inactive level (0, or 1 when its invert input is set).
- R2: While enabled, `hcount` advances by one each clock and wraps to 0 after live horizontal total minus 1. `vcount` advances at each wrap of `hcount` and wraps to 0 after live vertical total minus 1.
- R3: `de` is 1 exactly when enabled, `hcount` is below the active width (`act_size[15:0]`) and `vcount` is below the active height (`act_size[31:16]`).
- R4: Horizontal sync is active for `hcount` from active width plus right margin (`hmargin[15:0]`) up to, but not including, horizontal total minus left margin (`hmargin[31:16]`).
- R5: Vertical sync turns active at line (active height + lower gap `porch[15:0]`), pixel `hpos`. It turns inactive at line (vertical total − upper gap `porch[31:16]`), same pixel `hpos`. Both points are within the live field set.
- R6: With `interlace` set, each frame wrap toggles `field`, and the next field uses set B when `field` becomes 1 and set A when it becomes 0. With `interlace` clear, `field` stays 0 and set A is used.
- R7: Changes to any geometry input (totals, vertical gaps, VSYNC pixel, active size, horizontal margins) have no effect until the next frame wrap.
- R8: `inv_hs`, `inv_vs` and `inv_cs` each make their sync output active low. Composite sync is active whenever horizontal or vertical sync is active.
- R9: While disabled with `rgb24_mode` = 1, `pix_out` carries `blank_rgb`. In every other case `pix_out` follows `pix_in`.
- R10: Clearing `en` returns the counters to 0 and the field to 0 on the next clock. On the clock after `en` rises, `hcount` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Output enable; low holds the counters at 0 |
| interlace | input | 1 | 1 selects alternating A/B fields |
| rgb24_mode | input | 1 | 1 when the bus is in 24-bit RGB mode |
| inv_hs | input | 1 | Make HSYNC active low |
| inv_vs | input | 1 | Make VSYNC active low |
| inv_cs | input | 1 | Make composite sync active low |
| act_size | input | 32 | {active height, active width} |
| hmargin | input | 32 | {left margin, right margin} |
| tot_a | input | 32 | Set A {vertical total, horizontal total} |
| porch_a | input | 32 | Set A {upper gap, lower gap} |
| hpos_a | input | 16 | Set A VSYNC pixel position |
| tot_b | input | 32 | Set B {vertical total, horizontal total} |
| porch_b | input | 32 | Set B {upper gap, lower gap} |
| hpos_b | input | 16 | Set B VSYNC pixel position |
| blank_rgb | input | 24 | Colour driven while blanked in RGB24 mode |
| pix_in | input | 24 | Pixel data from upstream |
| hcount | output | 12 | Horizontal pixel count |
| vcount | output | 12 | Vertical line count |
| field | output | 1 | 0 first field, 1 second field |
| de | output | 1 | Data enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| pix_out | output | 24 | Pixel bus to the pins |

## Verification
The bench covers the field alternation. A design that reused one set for both fields would give two fields of the same length, and VSYNC would rise at the same pixel in each field. It also covers the mid-line VSYNC pixel. Placing VSYNC at pixel 0 of its line, or using the other field's pixel, shifts the rise and fall by a number of clocks that the per-cycle scoreboard catches. Geometry is rewritten in the middle of a field, so a design that loaded it at once would bend the current field's VSYNC window. The bench also toggles the invert bits and the disabled RGB24 state, so a missed polarity flip or a blank colour forced in the wrong bus mode shows on the pins.

// File: rtl/ilace_vtg_pkg.sv
package ilace_vtg_pkg;

  typedef struct packed {
    logic [15:0] vtot;
    logic [15:0] htot;
    logic [15:0] vtop;
    logic [15:0] vlow;
    logic [15:0] vs_hpos;
  } fset_t;

  typedef struct packed {
    logic [15:0] vact;
    logic [15:0] hact;
    logic [15:0] hleft;
    logic [15:0] hright;
  } hgeo_t;

  function automatic fset_t mk_fset(input logic [31:0] tot, input logic [31:0] porch,
                                    input logic [15:0] hpos);
    fset_t s;
    s.vtot    = tot[31:16];
    s.htot    = tot[15:0];
    s.vtop    = porch[31:16];
    s.vlow    = porch[15:0];
    s.vs_hpos = hpos;
    return s;
  endfunction

  function automatic hgeo_t mk_hgeo(input logic [31:0] act, input logic [31:0] hm);
    hgeo_t g;
    g.vact   = act[31:16];
    g.hact   = act[15:0];
    g.hleft  = hm[31:16];
    g.hright = hm[15:0];
    return g;
  endfunction

  // c lies in [lo, hi)
  function automatic logic in_span(input logic [15:0] c, input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (c >= lo) && (c < hi);
  endfunction

  // raster point (v,h) is at or past point (lv,lh)
  function automatic logic at_or_past(input logic [15:0] v, input logic [15:0] h,
                                      input logic [15:0] lv, input logic [15:0] lh);
    return (v > lv) || ((v == lv) && (h >= lh));
  endfunction

endpackage

// File: rtl/vtg_param_bank.sv
module vtg_param_bank
  import ilace_vtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        pick_b,
  input  logic [31:0] act_size,
  input  logic [31:0] hmargin,
  input  logic [31:0] tot_a,
  input  logic [31:0] porch_a,
  input  logic [15:0] hpos_a,
  input  logic [31:0] tot_b,
  input  logic [31:0] porch_b,
  input  logic [15:0] hpos_b,
  output fset_t       live_f,
  output hgeo_t       live_h
);
  localparam int NSETS = 2;

  logic [31:0] tot_in   [NSETS];
  logic [31:0] porch_in [NSETS];
  logic [15:0] hpos_in  [NSETS];
  fset_t       cand     [NSETS];

  assign tot_in[0]   = tot_a;
  assign tot_in[1]   = tot_b;
  assign porch_in[0] = porch_a;
  assign porch_in[1] = porch_b;
  assign hpos_in[0]  = hpos_a;
  assign hpos_in[1]  = hpos_b;

  for (genvar k = 0; k < NSETS; k++) begin : g_set
    assign cand[k] = mk_fset(tot_in[k], porch_in[k], hpos_in[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_f <= '0;
      live_h <= '0;
    end else if (load) begin
      live_f <= cand[pick_b];
      live_h <= mk_hgeo(act_size, hmargin);
    end
  end
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [15:0]   htot,
  input  logic [15:0]   vtot,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic          line_end,
  output logic          frame_end
);
  assign line_end  = en && (16'(hcnt) == htot - 16'd1);
  assign frame_end = line_end && (16'(vcnt) == vtot - 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !line_end) |=> (hcnt == $past(hcnt) + 1'b1));

  p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hcnt == '0 && vcnt == '0));
endmodule

// File: rtl/vtg_sync_out.sv
module vtg_sync_out
  import ilace_vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  fset_t         live_f,
  input  hgeo_t         live_h,
  input  logic          inv_hs,
  input  logic          inv_vs,
  input  logic          inv_cs,
  input  logic          rgb24_mode,
  input  logic [DW-1:0] blank_rgb,
  input  logic [DW-1:0] pix_in,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic [DW-1:0] pix_out
);
  logic [15:0] h16, v16;
  logic [15:0] hs_on, hs_off, vs_on_line, vs_off_line;
  logic        hs_act, vs_act, cs_act, blank_now;

  assign h16 = 16'(hcnt);
  assign v16 = 16'(vcnt);

  assign hs_on       = live_h.hact + live_h.hright;
  assign hs_off      = live_f.htot - live_h.hleft;
  assign vs_on_line  = live_h.vact + live_f.vlow;
  assign vs_off_line = live_f.vtot - live_f.vtop;

  assign hs_act = en && in_span(h16, hs_on, hs_off);
  assign vs_act = en && at_or_past(v16, h16, vs_on_line, live_f.vs_hpos)
                     && !at_or_past(v16, h16, vs_off_line, live_f.vs_hpos);
  assign cs_act = hs_act || vs_act;

  assign de    = en && (h16 < live_h.hact) && (v16 < live_h.vact);
  assign hsync = hs_act ^ inv_hs;
  assign vsync = vs_act ^ inv_vs;
  assign csync = cs_act ^ inv_cs;

  assign blank_now = !en && rgb24_mode;
  assign pix_out   = blank_now ? blank_rgb : pix_in;

  p_vs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_act) |-> (h16 == live_f.vs_hpos));
endmodule

// File: rtl/ilace_vtg.sv
module ilace_vtg
  import ilace_vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          interlace,
  input  logic          rgb24_mode,
  input  logic          inv_hs,
  input  logic          inv_vs,
  input  logic          inv_cs,
  input  logic [31:0]   act_size,
  input  logic [31:0]   hmargin,
  input  logic [31:0]   tot_a,
  input  logic [31:0]   porch_a,
  input  logic [15:0]   hpos_a,
  input  logic [31:0]   tot_b,
  input  logic [31:0]   porch_b,
  input  logic [15:0]   hpos_b,
  input  logic [DW-1:0] blank_rgb,
  input  logic [DW-1:0] pix_in,
  output logic [CW-1:0] hcount,
  output logic [CW-1:0] vcount,
  output logic          field,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic [DW-1:0] pix_out
);
  fset_t live_f;
  hgeo_t live_h;
  logic  line_end, frame_end;
  logic  next_field, bank_load;

  // field that follows the boundary; A (0) whenever progressive or idle
  assign next_field = en && interlace && !field;
  assign bank_load  = !en || frame_end;

  vtg_param_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load), .pick_b(next_field),
    .act_size(act_size), .hmargin(hmargin),
    .tot_a(tot_a), .porch_a(porch_a), .hpos_a(hpos_a),
    .tot_b(tot_b), .porch_b(porch_b), .hpos_b(hpos_b),
    .live_f(live_f), .live_h(live_h)
  );

  vtg_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en),
    .htot(live_f.htot), .vtot(live_f.vtot),
    .hcnt(hcount), .vcnt(vcount),
    .line_end(line_end), .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !en)  field <= 1'b0;
    else if (frame_end) field <= next_field;
  end

  vtg_sync_out #(.CW(CW), .DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(en),
    .hcnt(hcount), .vcnt(vcount),
    .live_f(live_f), .live_h(live_h),
    .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_cs(inv_cs),
    .rgb24_mode(rgb24_mode), .blank_rgb(blank_rgb), .pix_in(pix_in),
    .de(de), .hsync(hsync), .vsync(vsync), .csync(csync), .pix_out(pix_out)
  );

  p_prog_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!interlace && frame_end) |=> !field);

  p_field_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> $stable(field));

  p_live_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> ($stable(live_f) && $stable(live_h)));
endmodule

// File: tb/ilace_vtg_test.sv
module ilace_vtg_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n, en, interlace, rgb24_mode, inv_hs, inv_vs, inv_cs;
  logic [31:0] act_size, hmargin, tot_a, porch_a, tot_b, porch_b;
  logic [15:0] hpos_a, hpos_b;
  logic [DW-1:0] blank_rgb, pix_in;
  logic [CW-1:0] hcount, vcount;
  logic field, de, hsync, vsync, csync;
  logic [DW-1:0] pix_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilace_vtg #(.CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .interlace(interlace), .rgb24_mode(rgb24_mode),
    .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_cs(inv_cs),
    .act_size(act_size), .hmargin(hmargin),
    .tot_a(tot_a), .porch_a(porch_a), .hpos_a(hpos_a),
    .tot_b(tot_b), .porch_b(porch_b), .hpos_b(hpos_b),
    .blank_rgb(blank_rgb), .pix_in(pix_in),
    .hcount(hcount), .vcount(vcount), .field(field), .de(de),
    .hsync(hsync), .vsync(vsync), .csync(csync), .pix_out(pix_out)
  );

  typedef struct packed {
    logic [CW-1:0] h;
    logic [CW-1:0] v;
    logic f, de, hs, vs, cs;
    logic [DW-1:0] pix;
  } exp_t;

  exp_t exp_q[$];
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string phase = "R1";

  // reference model state
  int mh, mv, mf;
  int l_vtot, l_htot, l_top, l_low, l_hpos, l_vact, l_hact, l_left, l_right;

  task automatic load_set(input int b);
    l_vtot = b ? int'(tot_b[31:16])   : int'(tot_a[31:16]);
    l_htot = b ? int'(tot_b[15:0])    : int'(tot_a[15:0]);
    l_top  = b ? int'(porch_b[31:16]) : int'(porch_a[31:16]);
    l_low  = b ? int'(porch_b[15:0])  : int'(porch_a[15:0]);
    l_hpos = b ? int'(hpos_b)         : int'(hpos_a);
    l_vact = int'(act_size[31:16]);
    l_hact = int'(act_size[15:0]);
    l_left = int'(hmargin[31:16]);
    l_right = int'(hmargin[15:0]);
  endtask

  // driver side: expected item from the requirements
  task automatic push_expected();
    exp_t e;
    bit on, hs, vs;
    int pos, vs_lo, vs_hi;
    on = (en === 1'b1);
    pos   = mv * l_htot + mh;
    vs_lo = (l_vact + l_low) * l_htot + l_hpos;   // R5
    vs_hi = (l_vtot - l_top) * l_htot + l_hpos;
    hs = on && (mh >= l_hact + l_right) && (mh < l_htot - l_left);  // R4
    vs = on && (pos >= vs_lo) && (pos < vs_hi);
    e.h  = CW'(mh);
    e.v  = CW'(mv);
    e.f  = 1'(mf);
    e.de = on && (mh < l_hact) && (mv < l_vact);  // R3
    e.hs = hs ^ inv_hs;                             // R8
    e.vs = vs ^ inv_vs;
    e.cs = (hs || vs) ^ inv_cs;
    e.pix = (!on && rgb24_mode) ? blank_rgb : pix_in;  // R9
    exp_q.push_back(e);
  endtask

  task automatic step_model();
    if (!rst_n || !en) begin      // R10
      mh = 0; mv = 0; mf = 0; load_set(0);
    end else if (mh == l_htot - 1) begin
      mh = 0;
      if (mv == l_vtot - 1) begin // R6, R7: geometry taken only here
        mv = 0;
        mf = interlace ? 1 - mf : 0;
        load_set(mf);
      end else mv = mv + 1;
    end else mh = mh + 1;
  endtask

  task automatic cmp(input string req, input string name, input int got, input int exp);
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at h=%0d v=%0d",
               req, phase, name, got, exp, mh, mv);
    end
  endtask

  // monitor side: pop and compare against the design outputs
  always @(negedge clk) begin
    exp_t e;
    push_expected();
    e = exp_q.pop_front();
    vectors++;
    cmp("R2", "hcount", int'(hcount), int'(e.h));
    cmp("R2", "vcount", int'(vcount), int'(e.v));
    cmp("R6", "field", int'(field), int'(e.f));
    cmp("R3", "de", int'(de), int'(e.de));
    cmp("R4", "hsync", int'(hsync), int'(e.hs));
    cmp("R5", "vsync", int'(vsync), int'(e.vs));
    cmp("R8", "csync", int'(csync), int'(e.cs));
    cmp("R9", "pix_out", int'(pix_out), int'(e.pix));
    step_model();
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; interlace = 1'b0; rgb24_mode = 1'b1;
    inv_hs = 1'b0; inv_vs = 1'b0; inv_cs = 1'b0;
    act_size = {16'd6, 16'd12};
    hmargin  = {16'd3, 16'd2};
    tot_a = {16'd11, 16'd20}; porch_a = {16'd1, 16'd2}; hpos_a = 16'd4;
    tot_b = {16'd10, 16'd20}; porch_b = {16'd1, 16'd1}; hpos_b = 16'd14;
    blank_rgb = 24'h102030; pix_in = 24'hABCDEF;
    mh = 0; mv = 0; mf = 0; load_set(0);

    // R1: reset state, checked by the monitor while reset is held
    run(4);
    rst_n = 1'b1;
    phase = "R10";
    run(5);                         // disabled: counters parked, blank colour (R9)

    phase = "R2";                   // progressive raster, R3 R4 R5
    en = 1'b1;
    run(3 * 220);

    phase = "R6";                   // alternating fields
    interlace = 1'b1;
    run(5 * 220);

    phase = "R7";                   // rewrite geometry mid-field
    run(37);
    porch_a = {16'd1, 16'd3}; hpos_a = 16'd6;
    hmargin = {16'd2, 16'd3};
    tot_b = {16'd10, 16'd22};
    run(4 * 230);

    phase = "R8";                   // inverted sync polarities
    inv_hs = 1'b1; inv_vs = 1'b1; inv_cs = 1'b1;
    pix_in = 24'h55AA33;
    run(2 * 230);

    phase = "R10";                  // disable mid-frame in other bus mode
    en = 1'b0; rgb24_mode = 1'b0;   // R9: pins pass through
    run(6);
    rgb24_mode = 1'b1;              // R9: blank colour
    run(4);
    phase = "R2";
    interlace = 1'b0; inv_hs = 1'b0;
    en = 1'b1;
    run(300);

    phase = "R1";                   // reset during running
    rst_n = 1'b0; en = 1'b0;
    run(3);
    @(negedge clk); #1;
    finish_run();
  end
endmodule